// File: doc/BRIEF.md
# Paged I2C Register Slave

This block is an I2C target for standard and fast mode buses. It holds a small register file split into three pages. A 16-bit register pointer selects a location: its upper byte picks the page and its lower byte picks the register inside that page. A bus master loads the pointer with two bytes after a write-direction address byte. Any bytes that follow are stored at the pointer. To read, the master sends a repeated start and the read-direction address. The block then streams bytes back from the pointer. After every byte, in either direction, the pointer advances by one.

SCL and SDA are sampled with the system clock through two-flop synchronizers. SDA is driven open-drain: while `sdaOe` is high the pad pulls the line low, and otherwise the line is left to the pull-up. A static strap input selects one of two 7-bit target addresses. The block never stretches the clock. It ignores general call, 10-bit addressing and high-speed mode.

Top module: `i2cPagedRegSlave`

## Requirements
- R1: After reset, `sdaOe` is 0, every register holds 00h, and the pointer is page byte 30h, low byte 00h. A read issued before any pointer write therefore returns 00h.
- R2: A start (SDA falling while SCL is high) or a repeated start restarts target-address reception from any state, including in the middle of a byte. A stop (SDA rising while SCL is high) releases SDA and leaves the block idle.
- R3: The target address is 7'b0010000 when `addrSel` is 0 and 7'b0011010 when it is 1. A matching address byte is acknowledged. A mismatching one is not acknowledged, and every later byte up to the next start or stop is ignored, with no acknowledge and no register change.
- R4: Bytes travel MSB first, bit 0 of the address byte being the read flag (1 = read). The receiver acknowledges each byte in a ninth clock by holding SDA low. The block only begins pulling SDA low while SCL is low.
- R5: After a write-direction address byte, the next two bytes load the pointer, page byte first. Page bytes 30h, 31h and 32h select pages 0, 1 and 2. Any other page byte is not acknowledged, and the remaining bytes of that transfer neither get an acknowledge nor change any register.
- R6: Each data byte that follows the pointer bytes is written at the pointer, and the pointer's low byte then increments. The low byte wraps from FFh to 00h without changing the page. The register is picked by the low 4 bits of the low byte.
- R7: A read-direction address byte makes the block send the byte at the pointer and increment the low byte. When the master acknowledges, the block sends the next byte. When the master does not acknowledge, the block leaves SDA released until the next start or stop.
- R8: The three pages have separate storage. The same low byte in different pages addresses different registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock as seen at the pad |
| sdaIn | input | 1 | Bus data as seen at the pad (resolved line level) |
| addrSel | input | 1 | Strap choosing between the two target addresses |
| sdaOe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The assertions assume that SCL and SDA stay stable for several system clocks around each edge, so that the synchronized view follows the order of bus events. They also assume the master changes SDA only while SCL is low, except for start and stop, and that `addrSel` changes only while the bus is idle. The bench's master gives every SCL phase at least eight system clocks, changes data only in the low phase, and moves the strap only between transfers. This keeps the one-clock edge detection and the "drive only while SCL is low" property meaningful.

// File: rtl/i2cPagedPkg.sv
package i2cPagedPkg;

  // strobes from the bus controller to the datapath
  typedef struct packed {
    logic shiftIn;   // take the sampled SDA bit into the receive shifter
    logic capHi;     // load pointer page byte from the receive shifter
    logic capLo;     // load pointer low byte from the receive shifter
    logic wrByte;    // store received byte at pointer, advance pointer
    logic loadTx;    // fetch byte at pointer into transmit shifter, advance
    logic shiftTx;   // move to the next transmit bit
  } dpStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RECV, S_ACKOUT, S_SEND, S_ACKIN, S_WAIT
  } busState_t;

  typedef enum logic [1:0] {
    F_DEV, F_HI, F_LO, F_DATA
  } rxField_t;

endpackage

// File: rtl/i2cSlaveCtrl.sv
module i2cSlaveCtrl
  import i2cPagedPkg::*;
#(
  parameter logic [6:0] ADDR_LOW  = 7'h10,
  parameter logic [6:0] ADDR_HIGH = 7'h1A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       addrSel,
  input  logic [7:0] rxByte,
  input  logic       pageOk,
  input  logic       txBit,
  output dpStrobe_t  strobe,
  output logic       sdaBit,
  output logic       sdaOe
);

  logic [1:0] sclSync, sdaSync;
  logic       sclQ, sdaQ;
  logic       sclS, sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclQ    <= sclSync[1];
      sdaQ    <= sdaSync[1];
    end
  end

  assign sclS   = sclSync[1];
  assign sdaS   = sdaSync[1];
  assign sdaBit = sdaS;

  logic sclRise, sclFall, startEv, stopEv;
  assign sclRise = sclS & ~sclQ;
  assign sclFall = ~sclS & sclQ;
  assign startEv = sclS & sclQ & sdaQ & ~sdaS;
  assign stopEv  = sclS & sclQ & ~sdaQ & sdaS;

  logic [6:0] devAddr;
  assign devAddr = addrSel ? ADDR_HIGH : ADDR_LOW;

  busState_t state, stateN;
  rxField_t  field, fieldN;
  logic [3:0] bitCnt, cntN;
  logic ackDrive, ackN;
  logic goSend, sendN;
  logic masterAck, mAckN;

  always_comb begin
    stateN = state;
    fieldN = field;
    cntN   = bitCnt;
    ackN   = ackDrive;
    sendN  = goSend;
    mAckN  = masterAck;
    strobe = '0;
    if (startEv) begin
      stateN = S_RECV;
      fieldN = F_DEV;
      cntN   = 4'd0;
      ackN   = 1'b0;
      sendN  = 1'b0;
    end else if (stopEv) begin
      stateN = S_IDLE;
      ackN   = 1'b0;
    end else begin
      case (state)
        S_RECV: begin
          if (sclRise && bitCnt != 4'd8) begin
            strobe.shiftIn = 1'b1;
            cntN = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            stateN = S_ACKOUT;
            cntN   = 4'd0;
            ackN   = 1'b0;
            sendN  = 1'b0;
            case (field)
              F_DEV: begin
                if (rxByte[7:1] == devAddr) begin
                  ackN   = 1'b1;
                  sendN  = rxByte[0];
                  fieldN = F_HI;
                end
              end
              F_HI: begin
                if (pageOk) begin
                  ackN   = 1'b1;
                  strobe.capHi = 1'b1;
                  fieldN = F_LO;
                end
              end
              F_LO: begin
                ackN   = 1'b1;
                strobe.capLo = 1'b1;
                fieldN = F_DATA;
              end
              default: begin
                ackN   = 1'b1;
                strobe.wrByte = 1'b1;
              end
            endcase
          end
        end
        S_ACKOUT: begin
          if (sclFall) begin
            cntN = 4'd0;
            if (!ackDrive) begin
              stateN = S_WAIT;
            end else if (goSend) begin
              strobe.loadTx = 1'b1;
              stateN = S_SEND;
            end else begin
              stateN = S_RECV;
            end
          end
        end
        S_SEND: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              stateN = S_ACKIN;
            end else begin
              strobe.shiftTx = 1'b1;
              cntN = bitCnt + 4'd1;
            end
          end
        end
        S_ACKIN: begin
          if (sclRise) begin
            mAckN = ~sdaS;
          end else if (sclFall) begin
            if (masterAck) begin
              strobe.loadTx = 1'b1;
              stateN = S_SEND;
              cntN   = 4'd0;
            end else begin
              stateN = S_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      field     <= F_DEV;
      bitCnt    <= 4'd0;
      ackDrive  <= 1'b0;
      goSend    <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= stateN;
      field     <= fieldN;
      bitCnt    <= cntN;
      ackDrive  <= ackN;
      goSend    <= sendN;
      masterAck <= mAckN;
    end
  end

  assign sdaOe = (state == S_ACKOUT && ackDrive) || (state == S_SEND && !txBit);

  // R2: a stop always leaves the line released
  a_r2_stop_release: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !sdaOe);

  // R2: a start always restarts target-address reception
  a_r2_start_restart: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> (state == S_RECV && field == F_DEV && bitCnt == 4'd0));

  // R4: pulling SDA low begins only while the sampled SCL is low
  a_r4_drive_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclQ);

  // R7: a master NACK ends the read with the line released
  a_r7_nack_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ACKIN && sclFall && !masterAck && !startEv && !stopEv) |=> !sdaOe);

endmodule

// File: rtl/i2cSlaveData.sv
module i2cSlaveData
  import i2cPagedPkg::*;
#(
  parameter logic [7:0] PAGE_BASE  = 8'h30,
  parameter int         PAGE_COUNT = 3,
  parameter int         REG_AW     = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  input  logic       bitIn,
  output logic [7:0] rxByte,
  output logic       pageOk,
  output logic       txBit
);

  localparam int PG_W  = (PAGE_COUNT > 1) ? $clog2(PAGE_COUNT) : 1;
  localparam int IDX_W = PG_W + REG_AW;
  localparam int SLOTS = 1 << IDX_W;
  localparam logic [7:0] PAGE_HI = PAGE_BASE + 8'(PAGE_COUNT - 1);

  logic [7:0] rxShift, txShift, ptrHi, ptrLo;
  logic [7:0] regFile [SLOTS];
  logic [PG_W-1:0]  pageIdx;
  logic [IDX_W-1:0] idx;

  assign pageIdx = PG_W'(ptrHi - PAGE_BASE);
  assign idx     = {pageIdx, ptrLo[REG_AW-1:0]};
  assign rxByte  = rxShift;
  assign txBit   = txShift[7];
  assign pageOk  = (rxShift >= PAGE_BASE) && (rxShift <= PAGE_HI);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= 8'h00;
      txShift <= 8'hFF;
      ptrHi   <= PAGE_BASE;
      ptrLo   <= 8'h00;
    end else begin
      if (strobe.shiftIn) rxShift <= {rxShift[6:0], bitIn};
      if (strobe.capHi)   ptrHi   <= rxShift;
      if (strobe.capLo)   ptrLo   <= rxShift;
      if (strobe.wrByte)  ptrLo   <= ptrLo + 8'd1;
      if (strobe.loadTx) begin
        txShift <= regFile[idx];
        ptrLo   <= ptrLo + 8'd1;
      end else if (strobe.shiftTx) begin
        txShift <= {txShift[6:0], 1'b1};
      end
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regFile[s] <= 8'h00;
      else if (strobe.wrByte && idx == IDX_W'(s))
        regFile[s] <= rxShift;
    end
  end

  // R6: every stored or fetched byte advances the low pointer by one
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrByte || strobe.loadTx) |=> ptrLo == $past(ptrLo) + 8'd1);

  // R5: a captured page byte always names an existing page
  a_r5_page_valid: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capHi |=> (ptrHi >= PAGE_BASE && ptrHi <= PAGE_HI));

  // R6: pointer-moving strobes never coincide
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.capHi, strobe.capLo, strobe.wrByte, strobe.loadTx}));

endmodule

// File: rtl/i2cPagedRegSlave.sv
module i2cPagedRegSlave
  import i2cPagedPkg::*;
#(
  parameter logic [6:0] ADDR_LOW   = 7'h10,
  parameter logic [6:0] ADDR_HIGH  = 7'h1A,
  parameter logic [7:0] PAGE_BASE  = 8'h30,
  parameter int         PAGE_COUNT = 3,
  parameter int         REG_AW     = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic addrSel,
  output logic sdaOe
);

  dpStrobe_t  strobe;
  logic [7:0] rxByte;
  logic       pageOk, txBit, sdaBit;

  i2cSlaveCtrl #(
    .ADDR_LOW (ADDR_LOW),
    .ADDR_HIGH(ADDR_HIGH)
  ) ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .addrSel(addrSel),
    .rxByte (rxByte),
    .pageOk (pageOk),
    .txBit  (txBit),
    .strobe (strobe),
    .sdaBit (sdaBit),
    .sdaOe  (sdaOe)
  );

  i2cSlaveData #(
    .PAGE_BASE (PAGE_BASE),
    .PAGE_COUNT(PAGE_COUNT),
    .REG_AW    (REG_AW)
  ) data (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .bitIn (sdaBit),
    .rxByte(rxByte),
    .pageOk(pageOk),
    .txBit (txBit)
  );

endmodule

// File: tb/i2cPagedRegSlave_test.sv
`timescale 1ns/1ps
module i2cPagedRegSlave_test;

  localparam int Q = 8;  // system clocks per SCL quarter

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic addrSel = 1'b0;
  logic sdaOe;
  logic sdaBus;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign sdaBus = sdaM & ~sdaOe;

  i2cPagedRegSlave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .addrSel(addrSel), .sdaOe(sdaOe)
  );

  // page, low byte, data
  localparam logic [23:0] VEC [6] = '{
    24'h30_00_A5, 24'h30_07_3C, 24'h31_00_5A,
    24'h31_0F_C3, 24'h32_00_96, 24'h32_0A_E1
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic startC();
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b0; tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic stopC();
    sdaM = 1'b0; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b1; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; tick(Q);
      sclM = 1'b1; tick(2*Q);
      sclM = 1'b0; tick(Q);
    end
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q);
    ack = ~sdaBus;
    tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic getByte(input logic mAck, output logic [7:0] b);
    sdaM = 1'b1;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      sclM = 1'b1; tick(Q);
      b = {b[6:0], sdaBus};
      tick(Q);
      sclM = 1'b0;
    end
    tick(Q);
    sdaM = mAck ? 1'b0 : 1'b1; tick(Q);
    sclM = 1'b1; tick(2*Q);
    sclM = 1'b0; tick(Q);
    sdaM = 1'b1;
  endtask

  task automatic wrTxn(input logic [6:0] dev, input logic [7:0] hi, input logic [7:0] lo,
                       input logic [23:0] dat, input int n, output logic [5:0] acks);
    logic a;
    acks = '0;
    startC();
    sendByte({dev, 1'b0}, a); acks[0] = a;
    sendByte(hi, a); acks[1] = a;
    sendByte(lo, a); acks[2] = a;
    for (int k = 0; k < n; k++) begin
      sendByte(dat[23-8*k -: 8], a);
      acks[3+k] = a;
    end
    stopC();
  endtask

  task automatic rdTxn(input logic [6:0] dev, input logic [7:0] hi, input logic [7:0] lo,
                       input int n, output logic [23:0] dat, output logic [3:0] acks);
    logic a;
    logic [7:0] b;
    acks = '0;
    dat = '0;
    startC();
    sendByte({dev, 1'b0}, a); acks[0] = a;
    sendByte(hi, a); acks[1] = a;
    sendByte(lo, a); acks[2] = a;
    startC();
    sendByte({dev, 1'b1}, a); acks[3] = a;
    for (int k = 0; k < n; k++) begin
      getByte(k != n - 1, b);
      dat[23-8*k -: 8] = b;
    end
    stopC();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [5:0] wa;
    logic [3:0] ra;
    logic [23:0] rd;
    logic a;
    logic [7:0] b;

    tick(5);
    rstN = 1'b1;
    tick(5);

    // R1: released line, default pointer 3000h reads 00h
    chk("R1 sda released after reset", sdaOe, 0);
    startC();
    sendByte({7'h10, 1'b1}, a);
    chk("R1 read address ack", a, 1);
    getByte(1'b0, b);
    stopC();
    chk("R1 default register value", b, 8'h00);

    // table: write then read back each location
    foreach (VEC[i]) begin
      wrTxn(7'h10, VEC[i][23:16], VEC[i][15:8], {VEC[i][7:0], 16'h0}, 1, wa);
      chk("R4 R5 R6 write acks", wa[3:0], 4'hF);
      rdTxn(7'h10, VEC[i][23:16], VEC[i][15:8], 1, rd, ra);
      chk("R5 R7 read acks", ra, 4'hF);
      chk("R4 R7 readback", rd[23:16], VEC[i][7:0]);
    end
    // R8: all pages hold their own values
    foreach (VEC[i]) begin
      rdTxn(7'h10, VEC[i][23:16], VEC[i][15:8], 1, rd, ra);
      chk("R8 page independence", rd[23:16], VEC[i][7:0]);
    end
    chk("R2 released after stop", sdaOe, 0);

    // R6: burst write across the low-byte wrap inside page 31h
    wrTxn(7'h10, 8'h31, 8'hFE, 24'h112233, 3, wa);
    chk("R6 burst write acks", wa, 6'h3F);
    rdTxn(7'h10, 8'h31, 8'hFE, 3, rd, ra);
    chk("R7 burst read with increment", rd, 24'h112233);
    rdTxn(7'h10, 8'h31, 8'h00, 1, rd, ra);
    chk("R6 wrap stays in page", rd[23:16], 8'h33);
    rdTxn(7'h10, 8'h32, 8'h00, 1, rd, ra);
    chk("R6 next page untouched by wrap", rd[23:16], 8'h96);
    rdTxn(7'h10, 8'h31, 8'h0E, 1, rd, ra);
    chk("R6 low four bits select register", rd[23:16], 8'h11);

    // R5: invalid page byte
    wrTxn(7'h10, 8'h33, 8'h00, 24'h770000, 1, wa);
    chk("R5 bad page nack", wa[3:0], 4'b0001);
    wrTxn(7'h10, 8'h2F, 8'h07, 24'h770000, 1, wa);
    chk("R5 page below range nack", wa[3:0], 4'b0001);
    rdTxn(7'h10, 8'h30, 8'h00, 1, rd, ra);
    chk("R5 data after bad page ignored", rd[23:16], 8'hA5);
    rdTxn(7'h10, 8'h30, 8'h07, 1, rd, ra);
    chk("R5 pointer kept after bad page", rd[23:16], 8'h3C);

    // R3: wrong target address with strap 0
    wrTxn(7'h1A, 8'h30, 8'h00, 24'h550000, 1, wa);
    chk("R3 mismatch nack", wa[3:0], 4'b0000);
    rdTxn(7'h10, 8'h30, 8'h00, 1, rd, ra);
    chk("R3 mismatch ignored", rd[23:16], 8'hA5);

    // R3: strap 1
    addrSel = 1'b1;
    tick(Q);
    wrTxn(7'h1A, 8'h30, 8'h07, 24'h440000, 1, wa);
    chk("R3 strap high address ack", wa[3:0], 4'hF);
    rdTxn(7'h1A, 8'h30, 8'h07, 1, rd, ra);
    chk("R3 strap high readback", rd[23:16], 8'h44);
    wrTxn(7'h10, 8'h30, 8'h07, 24'h990000, 1, wa);
    chk("R3 strap high rejects low address", wa[3:0], 4'b0000);
    addrSel = 1'b0;
    tick(Q);

    // R2: repeated start in the middle of a byte restarts address reception
    startC();
    sendByte({7'h10, 1'b0}, a);
    for (int i = 0; i < 3; i++) begin
      sdaM = 1'b1; tick(Q);
      sclM = 1'b1; tick(2*Q);
      sclM = 1'b0; tick(Q);
    end
    wrTxn(7'h10, 8'h32, 8'h0A, 24'h5F0000, 1, wa);
    chk("R2 restart mid byte acks", wa[3:0], 4'hF);
    rdTxn(7'h10, 8'h32, 8'h0A, 1, rd, ra);
    chk("R2 restart mid byte data", rd[23:16], 8'h5F);

    // R7: master NACK ends the read; slave stays silent until stop
    startC();
    sendByte({7'h10, 1'b0}, a);
    sendByte(8'h30, a);
    sendByte(8'h00, a);
    startC();
    sendByte({7'h10, 1'b1}, a);
    getByte(1'b0, b);
    chk("R7 byte before nack", b, 8'hA5);
    getByte(1'b1, b);
    chk("R7 silent after nack", b, 8'hFF);
    stopC();
    chk("R2 released after final stop", sdaOe, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule